// File: doc/BRIEF.md
# Oscillator Settle Wait Timer

After a standby exit, the main oscillator needs time to settle before the processor can run safely. This block keeps the processor stalled for that settling time. It counts oscillator clock cycles from the moment a release starts. When the count reaches the chosen length, it drops the stall and raises a one-cycle ready pulse, and execution resumes.

A release can start in two ways. Reset always gives a fixed wait length. An interrupt wake request gives a length picked by a three-bit wait code. The wait code chooses one of four power-of-two counts. The block samples the code only at the moment the wait starts. While a wait is in progress, further wake requests and changes to the code are ignored. The four interrupt lengths and the reset length are parameters given as base-2 exponents. Their defaults are 20, 17, 15, 13 and 17.

Top module: `osc_settle_timer`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `cpu_hold` is 1 and `osc_ready` is 0.
- R2: After reset, `cpu_hold` stays high for exactly 2^EXP_RST cycles, counted from the last clock edge at which `rst` was high. This holds whatever value `wait_code` has.
- R3: A wake request accepted while idle starts a wait whose length depends on `wait_code`. Codes 000, 001 and 010 give 2^EXP_A cycles. Codes 011 and 100 give 2^EXP_B. Codes 101 and 110 give 2^EXP_C. Code 111 gives 2^EXP_D.
- R4: `cpu_hold` rises at the clock edge that samples an accepted wake request. It then stays high for exactly the selected number of cycles.
- R5: `osc_ready` is high for exactly one cycle: the cycle in which `cpu_hold` has just fallen. It is never high at the same time as `cpu_hold`, and it stays low while the block is idle.
- R6: A wake request that arrives during a wait has no effect. It does not restart or lengthen that wait.
- R7: A change to `wait_code` during a wait does not change the length of that wait.
- R8: The cycle counter clears at the start of every release, so repeated waits with the same code have identical lengths.
- R9: Reset asserted during an interrupt wait cancels that wait. A new wait of the reset length starts instead.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset; it also acts as a release |
| wake_req | input | 1 | Wake request from an interrupt; acted on only while idle |
| wait_code | input | 3 | Code that selects the wait length for interrupt releases |
| cpu_hold | output | 1 | High while processor execution must stay stalled |
| osc_ready | output | 1 | One-cycle pulse when the wait ends |

## Verification
Assertions check on every cycle that:
- the ready pulse lasts one cycle and never overlaps the stall;
- every fall of the stall produces a ready pulse;
- the latched length select stays fixed for the whole wait, so neither a wake request nor a code change during the wait can affect it;
- the counter reads zero after every release start;
- reset loads the fixed reset length.

The exact wait length for each of the eight codes, and for reset, can only be shown by the bench's scenarios. The same applies to the ignored mid-wait request, the ignored code rewrite, and reset cutting short an interrupt wait. The bench measures each of these by counting stalled cycles.

// File: rtl/osw_pkg.sv
package osw_pkg;

  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_WAIT = 1'b1} seq_state_t;

  localparam int unsigned NUM_LEN = 5;
  localparam int unsigned SEL_W   = 3;

  typedef logic [SEL_W-1:0] len_sel_t;

  localparam len_sel_t LEN_A   = 3'd0;
  localparam len_sel_t LEN_B   = 3'd1;
  localparam len_sel_t LEN_C   = 3'd2;
  localparam len_sel_t LEN_D   = 3'd3;
  localparam len_sel_t LEN_RST = 3'd4;

  // Undefined codes fall back to the nearest defined code below them.
  function automatic len_sel_t code_to_len(input logic [2:0] code);
    len_sel_t r;
    case (code)
      3'b000, 3'b001, 3'b010: r = LEN_A;
      3'b011, 3'b100:         r = LEN_B;
      3'b101, 3'b110:         r = LEN_C;
      default:                r = LEN_D;
    endcase
    return r;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/osw_code_decode.sv
module osw_code_decode
  import osw_pkg::*;
(
  input  logic [2:0] wait_code,
  output len_sel_t   len_sel
);

  always_comb begin
    len_sel = code_to_len(wait_code);
  end

  // R3: a mode code never selects the reset length
  always_comb begin
    a_r3_code_in_range: assert (len_sel <= LEN_D);
  end

endmodule

// File: rtl/osw_prescaler.sv
module osw_prescaler
  import osw_pkg::*;
#(
  parameter int unsigned CW = 20,
  parameter logic [NUM_LEN*8-1:0] EXP_PACK = {8'd17, 8'd13, 8'd15, 8'd17, 8'd20}
)(
  input  logic               clk,
  input  logic               clr,
  input  logic               en,
  output logic [NUM_LEN-1:0] term
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clr)     cnt <= '0;
    else if (en) cnt <= cnt + 1'b1;
  end

  // One terminal-count detector per selectable length.
  for (genvar i = 0; i < NUM_LEN; i++) begin : g_term
    localparam int unsigned E = int'(EXP_PACK[i*8 +: 8]);
    localparam logic [CW-1:0] LIM = CW'((64'd1 << E) - 64'd1);
    assign term[i] = (cnt == LIM);
  end

  // R8: every release start leaves the counter at zero
  a_r8_clear_on_start: assert property (@(posedge clk) clr |=> (cnt == '0));

endmodule

// File: rtl/osw_sequencer.sv
module osw_sequencer
  import osw_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wake_req,
  input  len_sel_t           req_len,
  input  logic [NUM_LEN-1:0] term,
  output logic               start,
  output logic               count_en,
  output logic               cpu_hold,
  output logic               osc_ready
);

  seq_state_t st;
  len_sel_t   sel_q;
  logic       done;

  assign start    = (st == ST_IDLE) && wake_req;
  assign count_en = (st == ST_WAIT);
  assign done     = (st == ST_WAIT) && term[sel_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_WAIT;
      sel_q     <= LEN_RST;
      cpu_hold  <= 1'b1;
      osc_ready <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          osc_ready <= 1'b0;
          if (wake_req) begin
            st       <= ST_WAIT;
            sel_q    <= req_len;
            cpu_hold <= 1'b1;
          end
        end
        default: begin
          if (done) begin
            st        <= ST_IDLE;
            cpu_hold  <= 1'b0;
            osc_ready <= 1'b1;
          end else begin
            osc_ready <= 1'b0;
          end
        end
      endcase
    end
  end

  // R1 / R2: reset stalls and loads the reset length
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (cpu_hold && !osc_ready && sel_q == LEN_RST));

  // R5: the ready pulse lasts one cycle and never overlaps the stall
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    osc_ready |=> !osc_ready);
  a_r5_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(osc_ready && cpu_hold));

  // R4: the stall only ends through a ready pulse
  a_r4_fall_gives_pulse: assert property (@(posedge clk) disable iff (rst)
    (cpu_hold && st == ST_WAIT && term[sel_q]) |=> (!cpu_hold && osc_ready));

  // R6 / R7: the latched length is frozen for the whole wait
  a_r6_wake_ignored: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT && !term[sel_q]) |=> (st == ST_WAIT && cpu_hold));
  a_r7_sel_held: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT) |=> (st == ST_IDLE || $stable(sel_q)));

endmodule

// File: rtl/osc_settle_timer.sv
module osc_settle_timer
  import osw_pkg::*;
#(
  parameter int unsigned EXP_A   = 20,
  parameter int unsigned EXP_B   = 17,
  parameter int unsigned EXP_C   = 15,
  parameter int unsigned EXP_D   = 13,
  parameter int unsigned EXP_RST = 17
)(
  input  logic       clk,
  input  logic       rst,
  input  logic       wake_req,
  input  logic [2:0] wait_code,
  output logic       cpu_hold,
  output logic       osc_ready
);

  localparam int unsigned CW =
    max2(max2(max2(EXP_A, EXP_B), max2(EXP_C, EXP_D)), EXP_RST);
  localparam logic [NUM_LEN*8-1:0] EXP_PACK =
    {8'(EXP_RST), 8'(EXP_D), 8'(EXP_C), 8'(EXP_B), 8'(EXP_A)};

  len_sel_t           req_len;
  logic [NUM_LEN-1:0] term;
  logic               start;
  logic               count_en;

  osw_code_decode u_dec (
    .wait_code (wait_code),
    .len_sel   (req_len)
  );

  osw_prescaler #(.CW(CW), .EXP_PACK(EXP_PACK)) u_cnt (
    .clk  (clk),
    .clr  (rst | start),
    .en   (count_en),
    .term (term)
  );

  osw_sequencer u_seq (
    .clk       (clk),
    .rst       (rst),
    .wake_req  (wake_req),
    .req_len   (req_len),
    .term      (term),
    .start     (start),
    .count_en  (count_en),
    .cpu_hold  (cpu_hold),
    .osc_ready (osc_ready)
  );

endmodule

// File: tb/osc_settle_timer_test.sv
`timescale 1ns/1ps
module osc_settle_timer_test;

  localparam int EA = 7, EB = 5, EC = 4, ED = 3, ER = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wake_req = 1'b0;
  logic [2:0] wait_code = 3'b000;
  logic       cpu_hold, osc_ready;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  osc_settle_timer #(.EXP_A(EA), .EXP_B(EB), .EXP_C(EC), .EXP_D(ED), .EXP_RST(ER)) uut (
    .clk(clk), .rst(rst), .wake_req(wake_req), .wait_code(wait_code),
    .cpu_hold(cpu_hold), .osc_ready(osc_ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  function automatic int exp_of(input logic [2:0] c);
    case (c)
      3'b000, 3'b001, 3'b010: return EA;
      3'b011, 3'b100:         return EB;
      3'b101, 3'b110:         return EC;
      default:                return ED;
    endcase
  endfunction

  // Called at the negedge after the starting edge; poke 1 = extra wake, 2 = code rewrite
  task automatic measure(input int e, input int poke, input logic [2:0] code, input string req);
    int n = 0;
    while (cpu_hold && n < 5000) begin
      n++;
      wake_req = (poke == 1 && n == 3);
      if (poke == 2 && n == 3) wait_code = ~code;
      @(negedge clk);
    end
    wake_req = 1'b0;
    chk(n == (1 << e), req, n, 1 << e);
    chk(osc_ready == 1'b1, {req, " R5 ready pulse"}, osc_ready, 1);
    @(negedge clk);
    chk(osc_ready == 1'b0 && cpu_hold == 1'b0, {req, " R5 pulse width"}, osc_ready, 0);
  endtask

  task automatic irq_wait(input logic [2:0] code, input int poke, input string req);
    @(negedge clk);
    wake_req = 1'b1;
    wait_code = code;
    @(negedge clk);
    wake_req = 1'b0;
    chk(cpu_hold == 1'b1, "R4 stall rises", cpu_hold, 1);
    measure(exp_of(code), poke, code, req);
  endtask

  task automatic do_reset(input logic [2:0] code);
    @(negedge clk);
    rst = 1'b1;
    wait_code = code;
    repeat (3) begin
      @(negedge clk);
      chk(cpu_hold == 1'b1 && osc_ready == 1'b0, "R1 reset state", cpu_hold, 1);
    end
    rst = 1'b0;
    measure(ER, 0, code, "R2 reset wait length");
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk(cpu_hold == 1'b1 && osc_ready == 1'b0, "R1 reset state", cpu_hold, 1);
    rst = 1'b0;
    measure(ER, 0, 3'b000, "R2 reset wait length");
    do_reset(3'b111);
    do_reset(3'b011);
    repeat (4) begin
      @(negedge clk);
      chk(osc_ready == 1'b0 && cpu_hold == 1'b0, "R5 idle quiet", osc_ready, 0);
    end
    for (int c = 0; c < 8; c++) irq_wait(3'(c), 0, "R3 code length");
    for (int c = 0; c < 8; c++) irq_wait(3'(c), 0, "R8 repeat length");
    irq_wait(3'b111, 1, "R6 mid-wait wake");
    irq_wait(3'b000, 1, "R6 mid-wait wake");
    irq_wait(3'b000, 2, "R7 code rewrite");
    irq_wait(3'b111, 2, "R7 code rewrite");
    irq_wait(3'b101, 2, "R7 code rewrite");
    @(negedge clk);
    wake_req = 1'b1;
    wait_code = 3'b000;
    @(negedge clk);
    wake_req = 1'b0;
    repeat (10) @(negedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(cpu_hold == 1'b1, "R9 reset in wait", cpu_hold, 1);
    rst = 1'b0;
    measure(ER, 0, 3'b000, "R9 reset replaces wait");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule